// File: doc/BRIEF.md
# Serial Configuration Port Controller

This block is the target side of a serial register-configuration link. A host frames each transaction with an active-low select (`cs_n`), clocks it with `sclk` and sends bits on `mosi`. The first two bytes form a command word. It holds a read/write flag, a 2-bit byte-count code and a 13-bit start address. The bytes that follow move data to or from a simple register-access port. The address steps by one after each byte. Read data returns on `miso`, together with an output-enable pin that the pad uses to release the line.

All serial inputs are resynchronised into the system clock `clk`. The controller therefore sees a rise of `cs_n` even while `sclk` is idle. It can then decide whether the rise is a permitted stall or an abort. Each `sclk` half period must last at least `SYNC_STAGES + 3` cycles of `clk`.

The bit order comes from a configuration input. That input normally comes from a control register outside this block. In LSB-first order each byte travels bit 0 first, the command word sends its low byte first, and the address counts down instead of up. A count code of zero selects a streaming transfer. Streaming runs until `cs_n` rises or until the byte at the burst-end address has been moved.

Top module: `spicfg_port`

## Requirements
- R1: After reset, `reg_we`, `reg_re` and `miso_oe` are low. A transaction starts at the first rising `sclk` edge with `cs_n` low. `mosi` is sampled on rising `sclk` edges.
- R2: In MSB-first order the command word travels bit 15 first, and its first byte is bits 15:8. Bit 15 selects read (1) or write (0). Bits 14:13 hold the count code. Bits 12:0 hold the start address.
- R3: Count code 01, 10 or 11 moves exactly one, two or three bytes. Code 00 streams. Further bytes produce no `reg_we` or `reg_re` until `cs_n` rises.
- R4: With `lsb_first`=0 the address rises by one after each data byte. With `lsb_first`=1 every byte is sent bit 0 first, the command word sends bits 7:0 first, and the address falls by one after each data byte.
- R5: In a write, after the eighth bit of each data byte, `reg_we` pulses for one `clk` cycle. During that pulse `reg_addr` holds the byte's address and `reg_wdata` holds the byte.
- R6: In a read, `reg_re` pulses for one cycle per data byte, and `reg_rdata` is taken in that same cycle. No request is made beyond the last byte. Each bit changes on `miso` after a falling `sclk` edge, so it is stable at the next rising edge.
- R7: `miso_oe` is high only while `cs_n` is low during the data bytes of a read. It is low during writes.
- R8: In a transfer of one to three bytes, `cs_n` may go high and return at any byte boundary without losing the transfer.
- R9: In a streaming transfer, `cs_n` may rise between the two command bytes or before the first data byte. A rise after the first data byte ends the transfer, and the next low `cs_n` starts a new command.
- R10: A streaming transfer stops after the byte whose address equals `burst_end`, zero-extended to 13 bits. Later bytes are ignored.
- R11: A rise of `cs_n` in the middle of a byte aborts the transaction. The partial byte is never written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low transaction select |
| mosi | input | 1 | Serial data from the host |
| lsb_first | input | 1 | 1 = bit 0 first and descending addresses |
| burst_end | input | 8 | Last address of a streaming transfer |
| miso | output | 1 | Serial read data to the host |
| miso_oe | output | 1 | Drive enable for `miso` |
| reg_we | output | 1 | Register write strobe |
| reg_re | output | 1 | Register read strobe |
| reg_addr | output | 13 | Register address for the strobe |
| reg_wdata | output | 8 | Register write data |
| reg_rdata | input | 8 | Register read data, valid in the `reg_re` cycle |

## Verification
The hardest condition to reach is a select rise that the block must classify. The classification depends on the transfer length, on whether any data byte has finished, and on whether the rise falls on a bit or a byte boundary. The bench builds each case on purpose:
- Stalls between every byte of a three-byte write.
- A stall inside the command word and before the first byte of a streaming write.
- A rise after one streamed byte, followed at once by a fresh single-byte command whose landing address shows whether the old stream survived.
- A rise after four data bits.

// File: rtl/spicfg_pkg.sv
package spicfg_pkg;
  localparam int ADDR_W = 13;
  localparam int BYTE_W = 8;
  localparam int CMD_W  = 2 * BYTE_W;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_CMD0,
    PH_CMD1,
    PH_DATA,
    PH_DONE
  } phase_e;

  // Accumulate one serial bit into a byte in the chosen order.
  function automatic logic [BYTE_W-1:0] shift_bit(logic [BYTE_W-1:0] sh, logic b, logic lsb);
    return lsb ? {b, sh[BYTE_W-1:1]} : {sh[BYTE_W-2:0], b};
  endfunction

  // Next address: up in MSB-first order, down in LSB-first order.
  function automatic logic [ADDR_W-1:0] step_addr(logic [ADDR_W-1:0] a, logic lsb);
    return lsb ? a - 1'b1 : a + 1'b1;
  endfunction

  function automatic logic at_burst_end(logic [ADDR_W-1:0] a, logic [BYTE_W-1:0] be);
    return a == ADDR_W'(be);
  endfunction
endpackage

// File: rtl/spicfg_sync.sv
module spicfg_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] pipe [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= RST_VAL;
    end else begin
      pipe[0] <= d_i;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign q_o = pipe[STAGES-1];
endmodule

// File: rtl/spicfg_frame.sv
module spicfg_frame
  import spicfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_rise,
  input  logic              cs_low,
  input  logic              cs_rise,
  input  logic              mosi_s,
  input  logic              lsb_first,
  input  logic [BYTE_W-1:0] burst_end,
  output logic              reg_we,
  output logic              reg_re,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [BYTE_W-1:0] reg_wdata,
  output logic              rd_data_phase
);
  phase_e            phase_q;
  logic [2:0]        bitcnt_q;
  logic [BYTE_W-1:0] sh_q, cmd0_q, wdata_q;
  logic              rw_q, stream_q, first_q, we_q, re_q;
  logic [1:0]        left_q;
  logic [ADDR_W-1:0] cur_q, addr_q;

  // Named events used by the logic and by the assertions.
  logic              bit_take, byte_end, stall_keep, last_byte;
  logic [BYTE_W-1:0] sh_nxt;
  logic [CMD_W-1:0]  cmd_word;

  assign bit_take   = sclk_rise && cs_low && (phase_q != PH_DONE);
  assign byte_end   = bit_take && (bitcnt_q == 3'd7);
  assign sh_nxt     = shift_bit(sh_q, mosi_s, lsb_first);
  assign cmd_word   = lsb_first ? {sh_nxt, cmd0_q} : {cmd0_q, sh_nxt};
  assign last_byte  = stream_q ? at_burst_end(cur_q, burst_end) : (left_q == 2'd1);
  assign stall_keep = (bitcnt_q == 3'd0) &&
                      ((phase_q == PH_CMD1) ||
                       ((phase_q == PH_DATA) && (!stream_q || first_q)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= PH_IDLE;
      bitcnt_q <= '0;
      sh_q     <= '0;
      cmd0_q   <= '0;
      wdata_q  <= '0;
      rw_q     <= 1'b0;
      stream_q <= 1'b0;
      first_q  <= 1'b0;
      left_q   <= '0;
      cur_q    <= '0;
      addr_q   <= '0;
      we_q     <= 1'b0;
      re_q     <= 1'b0;
    end else begin
      we_q <= 1'b0;
      re_q <= 1'b0;
      if (cs_rise) begin
        if (!stall_keep) begin
          phase_q  <= PH_IDLE;
          bitcnt_q <= '0;
        end
      end else if (bit_take) begin
        sh_q     <= sh_nxt;
        bitcnt_q <= bitcnt_q + 3'd1;
        if (phase_q == PH_IDLE) phase_q <= PH_CMD0;
        if (byte_end) begin
          unique case (phase_q)
            PH_CMD0: begin
              cmd0_q  <= sh_nxt;
              phase_q <= PH_CMD1;
            end
            PH_CMD1: begin
              rw_q     <= cmd_word[CMD_W-1];
              left_q   <= cmd_word[CMD_W-2 -: 2];
              stream_q <= (cmd_word[CMD_W-2 -: 2] == 2'b00);
              cur_q    <= cmd_word[ADDR_W-1:0];
              first_q  <= 1'b1;
              phase_q  <= PH_DATA;
              if (cmd_word[CMD_W-1]) begin
                re_q   <= 1'b1;
                addr_q <= cmd_word[ADDR_W-1:0];
              end
            end
            PH_DATA: begin
              first_q <= 1'b0;
              left_q  <= left_q - 2'd1;
              if (!rw_q) begin
                we_q    <= 1'b1;
                addr_q  <= cur_q;
                wdata_q <= sh_nxt;
              end
              if (last_byte) begin
                phase_q <= PH_DONE;
              end else begin
                cur_q <= step_addr(cur_q, lsb_first);
                if (rw_q) begin
                  re_q   <= 1'b1;
                  addr_q <= step_addr(cur_q, lsb_first);
                end
              end
            end
            default: ;
          endcase
        end
      end
    end
  end

  assign reg_we        = we_q;
  assign reg_re        = re_q;
  assign reg_addr      = addr_q;
  assign reg_wdata     = wdata_q;
  assign rd_data_phase = (phase_q == PH_DATA) && rw_q;

  // R5
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({we_q, re_q}));
  // R5
  we_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we_q |=> !we_q);
  // R4
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(phase_q) == PH_DATA && cur_q != $past(cur_q)) |-> cur_q == step_addr($past(cur_q), lsb_first));
  // R3
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_DONE && $past(phase_q) == PH_DONE) |-> (!we_q && !re_q));
  // R9
  stream_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise && phase_q == PH_DATA && stream_q && !first_q) |=> phase_q == PH_IDLE);
endmodule

// File: rtl/spicfg_tx.sv
module spicfg_tx #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] load_data_i,
  input  logic         fall_i,
  input  logic         shift_en_i,
  input  logic         lsb_i,
  output logic         miso_o
);
  logic [W-1:0] tx_q;
  logic         miso_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q   <= '0;
      miso_q <= 1'b0;
    end else if (load_i) begin
      tx_q <= load_data_i;
    end else if (fall_i && shift_en_i) begin
      miso_q <= lsb_i ? tx_q[0] : tx_q[W-1];
      tx_q   <= lsb_i ? {1'b0, tx_q[W-1:1]} : {tx_q[W-2:0], 1'b0};
    end
  end

  assign miso_o = miso_q;

  // R6
  load_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> $stable(miso_q));
endmodule

// File: rtl/spicfg_port.sv
module spicfg_port
  import spicfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              cs_n,
  input  logic              mosi,
  input  logic              lsb_first,
  input  logic [BYTE_W-1:0] burst_end,
  output logic              miso,
  output logic              miso_oe,
  output logic              reg_we,
  output logic              reg_re,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [BYTE_W-1:0] reg_wdata,
  input  logic [BYTE_W-1:0] reg_rdata
);
  logic [2:0] pins_s;
  logic       sclk_d, cs_d;
  logic       sclk_rise, sclk_fall, cs_rise, cs_low, rd_data_phase;

  spicfg_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i({cs_n, sclk, mosi}), .q_o(pins_s)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d <= 1'b0;
      cs_d   <= 1'b1;
    end else begin
      sclk_d <= pins_s[1];
      cs_d   <= pins_s[2];
    end
  end

  assign sclk_rise = pins_s[1] && !sclk_d;
  assign sclk_fall = !pins_s[1] && sclk_d;
  assign cs_rise   = pins_s[2] && !cs_d;
  assign cs_low    = !pins_s[2];

  spicfg_frame u_frame (
    .clk(clk), .rst_n(rst_n), .sclk_rise(sclk_rise), .cs_low(cs_low),
    .cs_rise(cs_rise), .mosi_s(pins_s[0]), .lsb_first(lsb_first),
    .burst_end(burst_end), .reg_we(reg_we), .reg_re(reg_re),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .rd_data_phase(rd_data_phase)
  );

  spicfg_tx #(.W(BYTE_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .load_i(reg_re), .load_data_i(reg_rdata),
    .fall_i(sclk_fall), .shift_en_i(rd_data_phase), .lsb_i(lsb_first),
    .miso_o(miso)
  );

  assign miso_oe = cs_low && rd_data_phase;

  // R7
  oe_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> !miso_oe);
endmodule

// File: tb/test_spicfg_port.sv
module test_spicfg_port;
  localparam int HALF = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0, lsb_first = 1'b0;
  logic [7:0] burst_end = 8'h00;
  logic miso, miso_oe, reg_we, reg_re;
  logic [12:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic [7:0] mem [64];
  int checks = 0, fails = 0, we_cnt = 0, re_cnt = 0;
  logic oe_any = 1'b0;

  always #4 clk = ~clk;

  spicfg_port i_spicfg_port (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
    .lsb_first(lsb_first), .burst_end(burst_end), .miso(miso),
    .miso_oe(miso_oe), .reg_we(reg_we), .reg_re(reg_re),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  function automatic logic [7:0] init_val(int a);
    return 8'(a) ^ 8'h5A;
  endfunction

  assign reg_rdata = mem[reg_addr[5:0]];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 64; i++) mem[i] <= init_val(i);
    end else begin
      if (reg_we) begin mem[reg_addr[5:0]] <= reg_wdata; we_cnt <= we_cnt + 1; end
      if (reg_re) re_cnt <= re_cnt + 1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer_bits(input logic [7:0] b, input int n, output logic [7:0] r);
    r = '0;
    for (int i = 0; i < n; i++) begin
      int idx;
      idx = lsb_first ? i : 7 - i;
      mosi = b[idx];
      wait_clk(HALF);
      r[idx] = miso;
      oe_any = oe_any | miso_oe;
      sclk = 1'b1;
      wait_clk(HALF);
      sclk = 1'b0;
    end
  endtask

  task automatic xfer(input logic [7:0] b, output logic [7:0] r);
    xfer_bits(b, 8, r);
  endtask

  task automatic cs_lo;
    wait_clk(2); cs_n = 1'b0; wait_clk(4);
  endtask

  task automatic cs_hi;
    wait_clk(HALF); cs_n = 1'b1; wait_clk(8);
  endtask

  // Send the command word; optionally stall between its two bytes.
  task automatic send_cmd(input logic rw, input logic [1:0] code, input logic [12:0] addr, input bit stall);
    logic [15:0] w;
    logic [7:0] r;
    w = {rw, code, addr};
    xfer(lsb_first ? w[7:0] : w[15:8], r);
    if (stall) begin cs_hi; cs_lo; end
    xfer(lsb_first ? w[15:8] : w[7:0], r);
  endtask

  task automatic t_reset;
    chk("R1 reset we", reg_we, 0);
    chk("R1 reset re", reg_re, 0);
    chk("R7 reset oe", miso_oe, 0);
  endtask

  task automatic t_write_msb;
    int w0;
    logic [7:0] r;
    w0 = we_cnt; oe_any = 0;
    cs_lo; send_cmd(1'b0, 2'b10, 13'h010, 0);
    xfer(8'hC3, r); xfer(8'h3C, r); cs_hi;
    chk("R2 R5 write byte0", mem[16], 8'hC3);
    chk("R4 write byte1 at +1", mem[17], 8'h3C);
    chk("R3 two writes", we_cnt - w0, 2);
    chk("R7 oe low in write", oe_any, 0);
  endtask

  task automatic t_read_msb;
    int r0;
    logic [7:0] r;
    r0 = re_cnt;
    cs_lo; send_cmd(1'b1, 2'b11, 13'h020, 0);
    oe_any = 0;
    xfer(8'h00, r); chk("R6 read byte0", r, init_val(32));
    xfer(8'h00, r); chk("R6 read byte1", r, init_val(33));
    xfer(8'h00, r); chk("R4 read byte2", r, init_val(34));
    cs_hi;
    chk("R6 three requests", re_cnt - r0, 3);
    chk("R7 oe high in read", oe_any, 1);
    chk("R7 oe low after cs high", miso_oe, 0);
  endtask

  task automatic t_lsb;
    logic [7:0] r;
    lsb_first = 1'b1; wait_clk(4);
    cs_lo; send_cmd(1'b0, 2'b10, 13'h008, 0);
    xfer(8'h81, r); xfer(8'h16, r); cs_hi;
    chk("R4 lsb write at start", mem[8], 8'h81);
    chk("R4 lsb write decrements", mem[7], 8'h16);
    cs_lo; send_cmd(1'b1, 2'b10, 13'h025, 0);
    xfer(8'h00, r); chk("R4 lsb read byte0", r, init_val(37));
    xfer(8'h00, r); chk("R4 lsb read byte1", r, init_val(36));
    cs_hi;
    lsb_first = 1'b0; wait_clk(4);
  endtask

  task automatic t_stall_fixed;
    int w0;
    logic [7:0] r;
    w0 = we_cnt;
    cs_lo; send_cmd(1'b0, 2'b11, 13'h018, 1);
    cs_hi; cs_lo; xfer(8'hA1, r);
    cs_hi; cs_lo; xfer(8'hA2, r);
    cs_hi; cs_lo; xfer(8'hA3, r); cs_hi;
    chk("R8 stalled writes", we_cnt - w0, 3);
    chk("R8 third byte", mem[26], 8'hA3);
  endtask

  task automatic t_burst_end;
    int w0;
    logic [7:0] r;
    w0 = we_cnt; burst_end = 8'h33;
    cs_lo; send_cmd(1'b0, 2'b00, 13'h030, 0);
    for (int i = 0; i < 6; i++) xfer(8'hD0 + 8'(i), r);
    cs_hi;
    chk("R10 writes until burst end", we_cnt - w0, 4);
    chk("R10 last written", mem[51], 8'hD3);
    chk("R10 beyond end untouched", mem[52], init_val(52));
  endtask

  task automatic t_stream_stall;
    int w0;
    logic [7:0] r;
    w0 = we_cnt; burst_end = 8'h3F;
    cs_lo; send_cmd(1'b0, 2'b00, 13'h028, 1);
    cs_hi; cs_lo;
    xfer(8'hE1, r); xfer(8'hE2, r); cs_hi;
    chk("R9 stream with early stalls", we_cnt - w0, 2);
    chk("R9 stream byte1", mem[41], 8'hE2);
  endtask

  task automatic t_stream_abort;
    logic [7:0] r;
    cs_lo; send_cmd(1'b0, 2'b00, 13'h038, 0);
    xfer(8'hB8, r); cs_hi; cs_lo;
    send_cmd(1'b0, 2'b01, 13'h03A, 0);
    xfer(8'hBA, r); cs_hi;
    chk("R9 first streamed byte", mem[56], 8'hB8);
    chk("R9 stream ended at cs rise", mem[57], init_val(57));
    chk("R9 new command after abort", mem[58], 8'hBA);
  endtask

  task automatic t_mid_abort;
    int w0;
    logic [7:0] r;
    w0 = we_cnt;
    cs_lo; send_cmd(1'b0, 2'b01, 13'h005, 0);
    xfer_bits(8'hFF, 4, r); cs_hi;
    chk("R11 partial byte not written", we_cnt - w0, 0);
    chk("R11 target untouched", mem[5], init_val(5));
    cs_lo; send_cmd(1'b0, 2'b01, 13'h005, 0);
    xfer(8'h77, r); cs_hi;
    chk("R11 recovery write", mem[5], 8'h77);
  endtask

  task automatic t_extra;
    int w0;
    logic [7:0] r;
    w0 = we_cnt;
    cs_lo; send_cmd(1'b0, 2'b01, 13'h00A, 0);
    xfer(8'h11, r); xfer(8'h22, r); xfer(8'h33, r); cs_hi;
    chk("R3 single write only", we_cnt - w0, 1);
    chk("R3 extra byte ignored", mem[11], init_val(11));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(5);
    t_reset;
    t_write_msb;
    t_read_msb;
    t_lsb;
    t_stall_fixed;
    t_burst_end;
    t_stream_stall;
    t_stream_abort;
    t_mid_abort;
    t_extra;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule